// File: doc/BRIEF.md
# RGB 3x3 Vector Median Filter

This block cleans impulse noise from a colour raster stream. Pixels arrive in raster order on a valid/ready stream. Each pixel carries 8-bit red, green and blue values, and the first pixel of a frame carries a start flag. Two line stores and a 3x3 register window give, for every position, the pixel and its eight neighbours.

For each interior position the block gives every one of the nine window pixels a score. The score is the sum, over the other eight pixels, of the squared red, green and blue differences. The pixel with the lowest score goes out in place of the centre. The output is always a colour that exists in the window; no new colour is blended. Pixels in the outer ring of the frame have no full window and pass through unchanged. The output frame therefore has the same size, order and pixel count as the input.

The stream sits between a frame source and a sink that can apply backpressure. Output lags input by one line plus one pixel. After the last pixel of a frame, the block drains that lag on its own before it takes the next frame.

Top module: `rgb_vmed_top`

## Requirements
- R1: For an interior position, the output is the window pixel with the smallest score. A window pixel's score is the sum, over the other eight window pixels, of (dR^2 + dG^2 + dB^2). The output is always one of the nine window pixels. Pixel value = {R[23:16], G[15:8], B[7:0]} on the out_r_o/out_g_o/out_b_o ports.
- R2: When several window pixels share the smallest score, the one with the lowest row-major window index wins. Index 0 is top-left, 4 is the centre and 8 is bottom-right.
- R3: Pixels in row 0, row IMG_H-1, column 0 and column IMG_W-1 leave the block unchanged.
- R4: Each frame yields exactly IMG_W*IMG_H output pixels in raster order. out_sof_o is 1 on the first of them and 0 on all others. After reset, out_valid_o is 0.
- R5: While out_valid_o is 1 and out_ready_i is 0, the output pixel and out_sof_o hold, and in_ready_o is 0.
- R6: With out_ready_i held at 1 and input valid every cycle, one pixel is accepted per cycle for a whole frame. After the last pixel, in_ready_o stays 0 for exactly IMG_W+1 cycles while the block drains. After reset, in_ready_o is 1.
- R7: A pixel accepted with in_sof_i = 1 becomes position (0,0). Nothing from earlier, partly sent data reaches the outputs of the new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input pixel valid |
| in_ready_o | output | 1 | Input pixel accepted when high with valid |
| in_sof_i | input | 1 | Input pixel is the first of a frame |
| in_r_i | input | CH_W | Input red |
| in_g_i | input | CH_W | Input green |
| in_b_i | input | CH_W | Input blue |
| out_valid_o | output | 1 | Output pixel valid |
| out_ready_i | input | 1 | Sink takes the output pixel |
| out_sof_o | output | 1 | Output pixel is the first of a frame |
| out_r_o | output | CH_W | Output red |
| out_g_o | output | CH_W | Output green |
| out_b_o | output | CH_W | Output blue |

## Verification
The assertions check the following on every cycle:
- a stalled output holds still, and no input is taken during a stall;
- the chosen window pixel never scores worse than the centre pixel, and its index is in range;
- the frame start flag only appears on a valid pixel.

Some behaviours need whole frames, so only the bench's scenarios show them:
- the exact choice among tied minimum scores;
- border pass-through;
- the output count per frame and the drain length;
- that a restart with the start flag flushes stale rows.

For these, the bench compares every output pixel against a brute-force model. It runs this on frames of random noise, impulse noise and two-level colours that force ties.

// File: rtl/rgb_vmed_pkg.sv
package rgb_vmed_pkg;
  localparam int unsigned WIN_DIM = 3;
  localparam int unsigned WIN_N   = WIN_DIM * WIN_DIM;
  localparam int unsigned CTR_IDX = WIN_N / 2;
  localparam int unsigned IDX_W   = $clog2(WIN_N);
  typedef logic [IDX_W-1:0] win_idx_t;
endpackage

// File: rtl/rgb_vmed_lbuf.sv
// Two chained row stores addressed by column: up1 = row above, up2 = two rows above.
module rgb_vmed_lbuf #(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned DW    = 24,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] up1_o,
  output logic [DW-1:0] up2_o
);
  logic [DW-1:0] row1_q [DEPTH];
  logic [DW-1:0] row2_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      row2_q[addr_i] <= row1_q[addr_i];
      row1_q[addr_i] <= wdata_i;
    end
  end

  assign up1_o = row1_q[addr_i];
  assign up2_o = row2_q[addr_i];
endmodule

// File: rtl/rgb_vmed_core.sv
// Scores all nine window pixels by summed squared RGB distance and picks the minimum.
module rgb_vmed_core import rgb_vmed_pkg::*; #(
  parameter int unsigned CH_W = 8,
  localparam int unsigned PX_W    = 3 * CH_W,
  localparam int unsigned SQ_W    = 2 * CH_W,
  localparam int unsigned DIST_W  = SQ_W + 2,
  localparam int unsigned SCORE_W = DIST_W + $clog2(WIN_N)
) (
  input  logic [PX_W-1:0]    win_i [WIN_N],
  output logic [PX_W-1:0]    sel_pix_o,
  output win_idx_t           sel_idx_o,
  output logic [SCORE_W-1:0] sel_score_o,
  output logic [SCORE_W-1:0] ctr_score_o
);
  function automatic logic [SQ_W-1:0] sqd(input logic [CH_W-1:0] a, input logic [CH_W-1:0] b);
    logic [SQ_W-1:0] d;
    d = SQ_W'((a > b) ? (a - b) : (b - a));
    return d * d;
  endfunction

  logic [DIST_W-1:0]  pd [WIN_N*WIN_N];
  logic [SCORE_W-1:0] score [WIN_N];
  win_idx_t           best_idx;
  logic [SCORE_W-1:0] best_s;

  // one distance per unordered pair; lower triangle tied to zero
  for (genvar i = 0; i < WIN_N; i++) begin : g_a
    for (genvar j = 0; j < WIN_N; j++) begin : g_b
      if (j > i) begin : g_calc
        assign pd[i*WIN_N+j] =
            DIST_W'(sqd(win_i[i][3*CH_W-1 -: CH_W], win_i[j][3*CH_W-1 -: CH_W])) +
            DIST_W'(sqd(win_i[i][2*CH_W-1 -: CH_W], win_i[j][2*CH_W-1 -: CH_W])) +
            DIST_W'(sqd(win_i[i][CH_W-1:0],         win_i[j][CH_W-1:0]));
      end else begin : g_zero
        assign pd[i*WIN_N+j] = '0;
      end
    end
  end

  always_comb begin
    for (int i = 0; i < WIN_N; i++) begin
      score[i] = '0;
      for (int j = 0; j < WIN_N; j++) begin
        if (j > i)      score[i] = score[i] + SCORE_W'(pd[i*WIN_N+j]);
        else if (j < i) score[i] = score[i] + SCORE_W'(pd[j*WIN_N+i]);
      end
    end
  end

  // strict compare keeps the lowest index on ties
  always_comb begin
    best_idx = '0;
    best_s   = score[0];
    for (int k = 1; k < WIN_N; k++) begin
      if (score[k] < best_s) begin
        best_s   = score[k];
        best_idx = win_idx_t'(k);
      end
    end
  end

  assign sel_pix_o   = win_i[best_idx];
  assign sel_idx_o   = best_idx;
  assign sel_score_o = best_s;
  assign ctr_score_o = score[CTR_IDX];
endmodule

// File: rtl/rgb_vmed_top.sv
module rgb_vmed_top import rgb_vmed_pkg::*; #(
  parameter int unsigned IMG_W = 128,
  parameter int unsigned IMG_H = 128,
  parameter int unsigned CH_W  = 8,
  localparam int unsigned PX_W    = 3 * CH_W,
  localparam int unsigned COL_W   = $clog2(IMG_W),
  localparam int unsigned ROW_W   = $clog2(IMG_H),
  localparam int unsigned LAG     = IMG_W + 1,
  localparam int unsigned FILL_W  = $clog2(LAG + 1),
  localparam int unsigned SCORE_W = 2 * CH_W + 2 + $clog2(WIN_N)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            in_valid_i,
  output logic            in_ready_o,
  input  logic            in_sof_i,
  input  logic [CH_W-1:0] in_r_i,
  input  logic [CH_W-1:0] in_g_i,
  input  logic [CH_W-1:0] in_b_i,
  output logic            out_valid_o,
  input  logic            out_ready_i,
  output logic            out_sof_o,
  output logic [CH_W-1:0] out_r_o,
  output logic [CH_W-1:0] out_g_o,
  output logic [CH_W-1:0] out_b_o
);
  logic              advance, in_fire, sof_fire, step, emit, last_in, last_out;
  logic              drain_q;
  logic [COL_W-1:0]  icol_q, col_eff, ocol_q;
  logic [ROW_W-1:0]  irow_q, row_eff, orow_q;
  logic [FILL_W-1:0] fill_q, fill_eff;
  logic [PX_W-1:0]   new_px, up1, up2;
  logic [PX_W-1:0]   win_q [WIN_N];
  logic              win_vld_q, win_border_q, win_sof_q;
  logic [PX_W-1:0]   sel_pix;
  win_idx_t          sel_idx;
  logic [SCORE_W-1:0] sel_score, ctr_score;
  logic              out_valid_q, out_sof_q;
  logic [PX_W-1:0]   out_px_q;

  assign advance    = !out_valid_q || out_ready_i;
  assign in_ready_o = advance && !drain_q;
  assign in_fire    = in_valid_i && in_ready_o;
  assign sof_fire   = in_fire && in_sof_i;
  // drain steps push dummy pixels to flush the last line + 1 centres
  assign step       = in_fire || (advance && drain_q);
  assign col_eff    = sof_fire ? '0 : icol_q;
  assign row_eff    = sof_fire ? '0 : irow_q;
  assign fill_eff   = sof_fire ? '0 : fill_q;
  assign new_px     = drain_q ? '0 : {in_r_i, in_g_i, in_b_i};
  assign emit       = step && (fill_eff == FILL_W'(LAG));
  assign last_in    = in_fire && (row_eff == ROW_W'(IMG_H-1)) && (col_eff == COL_W'(IMG_W-1));
  assign last_out   = emit && (orow_q == ROW_W'(IMG_H-1)) && (ocol_q == COL_W'(IMG_W-1));

  rgb_vmed_lbuf #(.DEPTH(IMG_W), .DW(PX_W)) u_lbuf (
    .clk_i  (clk_i),
    .we_i   (step),
    .addr_i (col_eff),
    .wdata_i(new_px),
    .up1_o  (up1),
    .up2_o  (up2)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      icol_q  <= '0;
      irow_q  <= '0;
      fill_q  <= '0;
      ocol_q  <= '0;
      orow_q  <= '0;
      drain_q <= 1'b0;
    end else begin
      if (step) begin
        if (col_eff == COL_W'(IMG_W-1)) begin
          icol_q <= '0;
          irow_q <= (row_eff == ROW_W'(IMG_H-1)) ? '0 : row_eff + ROW_W'(1);
        end else begin
          icol_q <= col_eff + COL_W'(1);
          irow_q <= row_eff;
        end
        fill_q <= emit ? fill_eff : fill_eff + FILL_W'(1);
      end
      if (sof_fire) begin
        ocol_q <= '0;
        orow_q <= '0;
      end else if (emit) begin
        if (ocol_q == COL_W'(IMG_W-1)) begin
          ocol_q <= '0;
          orow_q <= (orow_q == ROW_W'(IMG_H-1)) ? '0 : orow_q + ROW_W'(1);
        end else begin
          ocol_q <= ocol_q + COL_W'(1);
        end
      end
      if (last_in) drain_q <= 1'b1;
      if (last_out) begin
        drain_q <= 1'b0;
        icol_q  <= '0;
        irow_q  <= '0;
        fill_q  <= '0;
      end
    end
  end

  // window: shift left, new column enters on the right
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < WIN_N; k++) win_q[k] <= '0;
      win_vld_q    <= 1'b0;
      win_border_q <= 1'b0;
      win_sof_q    <= 1'b0;
    end else begin
      if (step) begin
        for (int r = 0; r < WIN_DIM; r++) begin
          for (int c = 0; c < WIN_DIM-1; c++) win_q[r*WIN_DIM+c] <= win_q[r*WIN_DIM+c+1];
        end
        win_q[WIN_DIM-1]   <= up2;
        win_q[2*WIN_DIM-1] <= up1;
        win_q[WIN_N-1]     <= new_px;
      end
      if (advance) begin
        win_vld_q    <= emit;
        win_border_q <= (orow_q == '0) || (orow_q == ROW_W'(IMG_H-1)) ||
                        (ocol_q == '0) || (ocol_q == COL_W'(IMG_W-1));
        win_sof_q    <= emit && (orow_q == '0) && (ocol_q == '0);
      end
    end
  end

  rgb_vmed_core #(.CH_W(CH_W)) u_core (
    .win_i      (win_q),
    .sel_pix_o  (sel_pix),
    .sel_idx_o  (sel_idx),
    .sel_score_o(sel_score),
    .ctr_score_o(ctr_score)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_q <= 1'b0;
      out_sof_q   <= 1'b0;
      out_px_q    <= '0;
    end else if (advance) begin
      out_valid_q <= win_vld_q;
      out_sof_q   <= win_vld_q && win_sof_q;
      if (win_vld_q) out_px_q <= win_border_q ? win_q[CTR_IDX] : sel_pix;
    end
  end

  assign out_valid_o = out_valid_q;
  assign out_sof_o   = out_sof_q;
  assign out_r_o     = out_px_q[3*CH_W-1 -: CH_W];
  assign out_g_o     = out_px_q[2*CH_W-1 -: CH_W];
  assign out_b_o     = out_px_q[CH_W-1:0];
endmodule

// File: rtl/rgb_vmed_chk.sv
module rgb_vmed_chk import rgb_vmed_pkg::*; #(
  parameter int unsigned PX_W    = 24,
  parameter int unsigned SCORE_W = 22
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               in_ready_i,
  input logic               out_valid_i,
  input logic               out_ready_i,
  input logic               out_sof_i,
  input logic [PX_W-1:0]    out_px_i,
  input logic               win_vld_i,
  input win_idx_t           sel_idx_i,
  input logic [SCORE_W-1:0] sel_score_i,
  input logic [SCORE_W-1:0] ctr_score_i
);
  // R5
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_i && !out_ready_i |=> out_valid_i && $stable(out_px_i) && $stable(out_sof_i));
  // R5
  stall_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_i && !out_ready_i |-> !in_ready_i);
  // R1
  argmin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_vld_i |-> sel_score_i <= ctr_score_i);
  // R1
  sel_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_vld_i |-> 32'(sel_idx_i) < WIN_N);
  // R4
  sof_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_sof_i |-> out_valid_i);
endmodule

bind rgb_vmed_top rgb_vmed_chk #(.PX_W(PX_W), .SCORE_W(SCORE_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_ready_i (in_ready_o),
  .out_valid_i(out_valid_o),
  .out_ready_i(out_ready_i),
  .out_sof_i  (out_sof_o),
  .out_px_i   (out_px_q),
  .win_vld_i  (win_vld_q),
  .sel_idx_i  (sel_idx),
  .sel_score_i(sel_score),
  .ctr_score_i(ctr_score)
);

// File: tb/tb_rgb_vmed_top.sv
module tb_rgb_vmed_top;
  localparam int W = 128;
  localparam int H = 128;
  localparam int N = W * H;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic       in_valid = 1'b0, in_sof = 1'b0, out_ready = 1'b1;
  logic [7:0] in_r = '0, in_g = '0, in_b = '0;
  logic       in_ready, out_valid, out_sof;
  logic [7:0] out_r, out_g, out_b;

  rgb_vmed_top dut (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_sof_i(in_sof),
    .in_r_i(in_r), .in_g_i(in_g), .in_b_i(in_b),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_sof_o(out_sof),
    .out_r_o(out_r), .out_g_o(out_g), .out_b_o(out_b)
  );

  int total = 0, bad = 0;
  longint cyc = 0;
  logic stall_en = 1'b0;
  longint first_acc, last_acc;
  int drain_cnt;

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) out_ready <= stall_en ? (($urandom % 3) != 0) : 1'b1;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mix(input logic [31:0] a);
    logic [31:0] x;
    x = a;
    x = x ^ (x >> 16); x = x * 32'h7feb352d;
    x = x ^ (x >> 15); x = x * 32'h846ca68b;
    x = x ^ (x >> 16);
    return x;
  endfunction

  // mode 0: random, 1: gradient with impulses, 2: two-level channels (ties)
  function automatic logic [23:0] pix(input int mode, input int seed, input int r, input int c);
    logic [31:0] h;
    h = mix(32'(seed) * 32'd65536 + 32'(r * W + c));
    case (mode)
      0: return h[23:0];
      1: begin
        if (h[31:28] == 4'd0) return h[27] ? 24'hFFFFFF : 24'h000000;
        return {8'(r * 2), 8'(c * 2), 8'(r + c)};
      end
      default: return {8'(h[0] * 50), 8'(h[8] * 50), 8'(h[16] * 50)};
    endcase
  endfunction

  function automatic int sqd(input logic [23:0] a, input logic [23:0] b);
    int dr, dg, db;
    dr = int'(a[23:16]) - int'(b[23:16]);
    dg = int'(a[15:8])  - int'(b[15:8]);
    db = int'(a[7:0])   - int'(b[7:0]);
    return dr*dr + dg*dg + db*db;
  endfunction

  function automatic logic [23:0] model(input int mode, input int seed, input int r, input int c,
                                        output bit border, output bit tie);
    logic [23:0] w [9];
    int s [9];
    int best;
    border = (r == 0) || (r == H-1) || (c == 0) || (c == W-1);
    tie = 1'b0;
    if (border) return pix(mode, seed, r, c);
    for (int k = 0; k < 9; k++) w[k] = pix(mode, seed, r + k/3 - 1, c + k%3 - 1);
    for (int i = 0; i < 9; i++) begin
      s[i] = 0;
      for (int j = 0; j < 9; j++) if (j != i) s[i] += sqd(w[i], w[j]);
    end
    best = 0;
    for (int i = 1; i < 9; i++) if (s[i] < s[best]) best = i;
    for (int i = 0; i < 9; i++) if (i != best && s[i] == s[best] && w[i] != w[best]) tie = 1'b1;
    return w[best];
  endfunction

  task automatic drive(input int mode, input int seed, input int npix);
    for (int k = 0; k < npix; k++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_sof   = (k == 0);
      {in_r, in_g, in_b} = pix(mode, seed, k / W, k % W);
      #5;
      while (!in_ready) begin
        @(negedge clk);
        #5;
      end
      if (k == 0) first_acc = cyc;
      last_acc = cyc;
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_sof   = 1'b0;
    drain_cnt = 0;
    #5;
    while (!in_ready && drain_cnt < 4 * W) begin
      drain_cnt++;
      @(negedge clk);
      #5;
    end
  endtask

  task automatic collect(input int mode, input int seed, input string req);
    int k;
    bit prev_stall, border, tie;
    logic [24:0] prev_val;
    logic [23:0] exp_px;
    string lbl;
    k = 0;
    prev_stall = 1'b0;
    prev_val = '0;
    while (k < N) begin
      @(negedge clk);
      #6;
      if (prev_stall)
        check(out_valid && {out_sof, out_r, out_g, out_b} == prev_val, "R5",
              {7'd0, out_sof, out_r, out_g, out_b}, {7'd0, prev_val});
      prev_stall = out_valid && !out_ready;
      prev_val   = {out_sof, out_r, out_g, out_b};
      if (out_valid && out_ready) begin
        exp_px = model(mode, seed, k / W, k % W, border, tie);
        lbl = border ? "R3" : (tie ? "R2" : req);
        check({out_r, out_g, out_b} == exp_px, lbl, {8'd0, out_r, out_g, out_b}, {8'd0, exp_px});
        check(out_sof == (k == 0), "R4", 32'(out_sof), 32'(k == 0));
        k++;
      end
    end
  endtask

  task automatic count_extra(input int cycles, output int n);
    n = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      #6;
      if (out_valid && out_ready) n++;
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    #6;
    check(out_valid == 1'b0, "R4", 32'(out_valid), 0);
    check(in_ready == 1'b1, "R6", 32'(in_ready), 1);
  endtask

  task automatic t_frame(input int mode, input int seed, input bit stall, input string req);
    int extra;
    stall_en = stall;
    fork
      drive(mode, seed, N);
      collect(mode, seed, req);
    join
    stall_en = 1'b0;
    count_extra(3 * W, extra);
    check(extra == 0, "R4", 32'(extra), 0);
    if (!stall) begin
      check(last_acc - first_acc == N - 1, "R6", 32'(last_acc - first_acc), 32'(N - 1));
      check(drain_cnt == W + 1, "R6", 32'(drain_cnt), 32'(W + 1));
    end
  endtask

  // partial frame of junk, then a start-flagged frame must come out clean
  task automatic t_restart();
    int seen;
    stall_en = 1'b0;
    fork
      drive(0, 77, 3 * W + 5);
      count_extra(6 * W, seen);
    join
    check(seen == 2 * W + 4, "R7", 32'(seen), 32'(2 * W + 4));
    t_frame(1, 91, 1'b0, "R7");
  endtask

  initial begin
    #(64'd190000 * 20);
    total++;
    bad++;
    $display("FAIL watchdog act=%0d exp=done", cyc);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_frame(0, 1, 1'b0, "R1");
    t_frame(1, 2, 1'b0, "R1");
    t_frame(2, 3, 1'b0, "R2");
    t_frame(0, 4, 1'b1, "R5");
    t_restart();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule